// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Error Detection

This block turns the bit stream on one asynchronous serial input back into characters. It runs from the system clock and uses a one-cycle enable pulse, `tick16`, that arrives sixteen times per bit period. That is the same oversampling tick a matching transmitter uses. The word length (5 to 8 bits) and the parity rule are set at runtime through configuration inputs. The receiver looks for a start bit, re-times itself on every new start bit, samples each bit once in its middle, and checks the parity bit and the stop bit.

A completed character lands in a one-entry holding register, and the ready flag goes high. The consumer takes the character by pulsing `data_rd`. Four sticky error flags record line problems: overrun, parity, framing and break. They stay set until the consumer pulses `stat_rd`. The block has no queue, no interrupt logic and no infrared decoding. A parent block can add these around it.

Top module: `async_rx`

## Requirements
- R1: After reset, `rx_ready` is 0, `rx_byte` is 0 and all four error flags are 0.
- R2: In idle, a low level seen on a tick starts a start bit. The line is sampled again eight ticks later. If the line is high at that point, the event is a glitch: nothing is loaded and no flag changes.
- R3: Data bits arrive least significant first. `cfg_len` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `rx_byte` above the word length read as 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_odd` = 1 asks for an odd count of ones over data and parity; 0 asks for an even count. A mismatch sets `err_parity`, and the character is still delivered.
- R5: A stop bit sampled as 0, in a frame that held at least one 1, sets `err_frame` and still delivers the character. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: A frame whose samples were all 0, including the stop bit, sets `err_break` and not `err_frame`. It loads nothing and leaves `rx_ready` unchanged. The receiver then waits for the line to go high, after which it receives normally.
- R7: A delivered character sets `rx_ready`. A `data_rd` pulse clears it.
- R8: If a character completes while `rx_ready` is 1 and no `data_rd` arrives in the same cycle, `err_overrun` is set. The new character is discarded and `rx_byte` keeps the unread one.
- R9: Error flags stay set until a `stat_rd` pulse clears them. A new error in the same cycle as the clear takes priority.
- R10: A new start bit that follows the stop bit with no idle time between them is received correctly, because timing is realigned on every start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_line | input | 1 | Serial input, idle high |
| cfg_len | input | 2 | Word length select (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| data_rd | input | 1 | Pulse: consume the held character |
| stat_rd | input | 1 | Pulse: clear the error flags |
| rx_byte | output | 8 | Received character, right-aligned |
| rx_ready | output | 1 | Character held and unread |
| err_overrun | output | 1 | Sticky: character lost to an unread one |
| err_parity | output | 1 | Sticky: parity mismatch |
| err_frame | output | 1 | Sticky: stop bit read as 0 |
| err_break | output | 1 | Sticky: line low for a whole frame |

## Verification
Results for a frame are due a fixed number of cycles after the tick that samples the middle of the stop bit. The two synchronizer stages add delay before that tick. After it, one cycle carries the frame pulse and one more updates the holding register and the flags. The whole path is well under one bit period. The bench therefore samples every frame result half a bit after the stop-bit midpoint, at the end of the stop bit, on a falling clock edge. Read and clear pulses last one cycle, and their effect is sampled on the next falling edge. Glitch and break checks wait several bit periods so that any wrong load would already have shown.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int WORD_MAX = 8;
  localparam int LEN_MIN = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rx_state_t;

  // number of data bits for a length select code
  function automatic logic [3:0] word_bits(input logic [1:0] sel);
    return 4'(LEN_MIN) + {2'b00, sel};
  endfunction

  // bits enter from the top, so shift down by the unused positions
  function automatic logic [WORD_MAX-1:0] align_word(input logic [WORD_MAX-1:0] sh,
                                                     input logic [1:0] sel);
    logic [3:0] unused;
    unused = 4'(WORD_MAX) - word_bits(sel);
    return sh >> unused;
  endfunction

  // parity holds when total ones over data and parity bit match the rule
  function automatic logic parity_ok(input logic [WORD_MAX-1:0] d, input logic pbit,
                                     input logic odd);
    return ((^d) ^ pbit) == odd;
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                line,
  input  logic [1:0]          cfg_len,
  input  logic                par_en,
  input  logic                par_odd,
  output logic                done,
  output logic [WORD_MAX-1:0] word,
  output logic                perr,
  output logic                ferr,
  output logic                brk,
  output logic                glitch
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(WORD_MAX);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_t           state;
  logic [CW-1:0]       cnt;
  logic [IW-1:0]       idx;
  logic [WORD_MAX-1:0] shreg;
  logic                all_low;
  logic                pbit;
  logic [IW-1:0]       last_idx;
  logic [WORD_MAX-1:0] aligned;

  assign last_idx = IW'(word_bits(cfg_len) - 4'd1);
  assign aligned  = align_word(shreg, cfg_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      all_low <= 1'b0;
      pbit    <= 1'b0;
      done    <= 1'b0;
      word    <= '0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      brk     <= 1'b0;
      glitch  <= 1'b0;
    end else begin
      done   <= 1'b0;
      glitch <= 1'b0;
      case (state)
        S_IDLE: begin
          if (tick && !line) begin
            state <= S_START;
            cnt   <= '0;
          end
        end
        S_START: begin
          if (tick) begin
            if (cnt == MID) begin
              cnt <= '0;
              if (line) begin
                state  <= S_IDLE;
                glitch <= 1'b1;
              end else begin
                state   <= S_DATA;
                idx     <= '0;
                shreg   <= '0;
                all_low <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (tick) begin
            if (cnt == LAST) begin
              cnt     <= '0;
              shreg   <= {line, shreg[WORD_MAX-1:1]};
              all_low <= all_low & ~line;
              if (idx == last_idx) state <= par_en ? S_PAR : S_STOP;
              else                 idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_PAR: begin
          if (tick) begin
            if (cnt == LAST) begin
              cnt     <= '0;
              pbit    <= line;
              all_low <= all_low & ~line;
              state   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_STOP: begin
          if (tick) begin
            if (cnt == LAST) begin
              cnt   <= '0;
              done  <= 1'b1;
              word  <= aligned;
              perr  <= par_en && !parity_ok(aligned, pbit, par_odd);
              ferr  <= !line && !all_low;
              brk   <= !line && all_low;
              state <= line ? S_IDLE : S_HOLD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_HOLD: begin
          if (line) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_status.sv
module rx_status
  import rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done,
  input  logic [WORD_MAX-1:0] word,
  input  logic                perr,
  input  logic                ferr,
  input  logic                brk,
  input  logic                data_rd,
  input  logic                stat_rd,
  output logic                load,
  output logic                ovr_evt,
  output logic [WORD_MAX-1:0] rx_byte,
  output logic                rx_ready,
  output logic                err_overrun,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_break
);
  logic good;

  assign good    = done && !brk;
  assign load    = good && (!rx_ready || data_rd);
  assign ovr_evt = good && rx_ready && !data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte     <= '0;
      rx_ready    <= 1'b0;
      err_overrun <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_break   <= 1'b0;
    end else begin
      if (load) begin
        rx_byte  <= word;
        rx_ready <= 1'b1;
      end else if (data_rd) begin
        rx_ready <= 1'b0;
      end
      err_overrun <= (err_overrun & ~stat_rd) | ovr_evt;
      err_parity  <= (err_parity  & ~stat_rd) | (good & perr);
      err_frame   <= (err_frame   & ~stat_rd) | (done & ferr);
      err_break   <= (err_break   & ~stat_rd) | (done & brk);
    end
  end
endmodule

// File: rtl/async_rx.sv
module async_rx #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_line,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       data_rd,
  input  logic       stat_rd,
  output logic [7:0] rx_byte,
  output logic       rx_ready,
  output logic       err_overrun,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_break
);
  logic       line_s;
  logic       frame_done;
  logic [7:0] frame_word;
  logic       frame_perr;
  logic       frame_ferr;
  logic       frame_brk;
  logic       start_glitch;
  logic       word_load;
  logic       overrun_evt;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  rx_framer #(.OVS(OVS)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line_s),
    .cfg_len(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .done(frame_done), .word(frame_word), .perr(frame_perr),
    .ferr(frame_ferr), .brk(frame_brk), .glitch(start_glitch)
  );

  rx_status u_status (
    .clk(clk), .rst_n(rst_n), .done(frame_done), .word(frame_word),
    .perr(frame_perr), .ferr(frame_ferr), .brk(frame_brk),
    .data_rd(data_rd), .stat_rd(stat_rd),
    .load(word_load), .ovr_evt(overrun_evt),
    .rx_byte(rx_byte), .rx_ready(rx_ready), .err_overrun(err_overrun),
    .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break)
  );
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       data_rd,
  input logic       stat_rd,
  input logic       frame_done,
  input logic       frame_brk,
  input logic       frame_ferr,
  input logic       start_glitch,
  input logic [7:0] rx_byte,
  input logic       rx_ready,
  input logic       err_overrun,
  input logic       err_parity,
  input logic       err_frame,
  input logic       err_break
);
  p_glitch_no_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_glitch |-> !frame_done);

  p_break_not_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !(frame_brk && frame_ferr));

  p_break_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_brk && !data_rd |=> rx_ready == $past(rx_ready) && $stable(rx_byte) && err_break);

  p_ready_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_brk |=> rx_ready);

  p_ready_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !frame_done |=> !rx_ready);

  p_overrun_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_brk && rx_ready && !data_rd |=> err_overrun && $stable(rx_byte));

  p_frame_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame && !stat_rd |=> err_frame);

  p_parity_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity && !stat_rd |=> err_parity);

  p_flags_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !frame_done |=> !(err_overrun || err_parity || err_frame || err_break));
endmodule

bind async_rx async_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .stat_rd(stat_rd),
  .frame_done(frame_done), .frame_brk(frame_brk), .frame_ferr(frame_ferr),
  .start_glitch(start_glitch), .rx_byte(rx_byte), .rx_ready(rx_ready),
  .err_overrun(err_overrun), .err_parity(err_parity), .err_frame(err_frame),
  .err_break(err_break)
);

// File: tb/sim_async_rx.sv
`timescale 1ns/1ps
module sim_async_rx;
  localparam int BIT_CLK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       data_rd = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_ready;
  logic       err_overrun, err_parity, err_frame, err_break;
  logic [1:0] tdiv;
  int nvec = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      tdiv <= 2'd0;
      tick16 <= 1'b0;
    end else begin
      tdiv <= tdiv + 2'd1;
      tick16 <= (tdiv == 2'd3);
    end
  end

  async_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .data_rd(data_rd), .stat_rd(stat_rd), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .err_overrun(err_overrun), .err_parity(err_parity), .err_frame(err_frame),
    .err_break(err_break)
  );

  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (3 - len);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic [1:0] len, input logic odd);
    logic x;
    x = ^(d & len_mask(len));
    return odd ? ~x : x;
  endfunction

  function automatic logic [7:0] flags();
    return {4'd0, err_overrun, err_break, err_frame, err_parity};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    rx_line = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic flip, input logic stop_v);
    bit_out(1'b0);
    for (int i = 0; i < 5 + cfg_len; i++) bit_out(d[i]);
    if (cfg_par_en) bit_out(par_of(d, cfg_len, cfg_par_odd) ^ flip);
    bit_out(stop_v);
    rx_line = 1'b1;
  endtask

  task automatic rd_data();
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
  endtask

  task automatic rd_stat();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d, expb;
    logic flip;
    repeat (5) @(negedge clk);
    chk("R1 ready", {7'd0, rx_ready}, 8'd0);
    chk("R1 byte", rx_byte, 8'd0);
    chk("R1 flags", flags(), 8'd0);
    rst_n = 1'b1;
    idle(40);

    // R3 R7: 8-bit word, no parity
    send(8'hA5, 1'b0, 1'b1);
    chk("R7 ready set", {7'd0, rx_ready}, 8'd1);
    chk("R3 byte 8b", rx_byte, 8'hA5);
    rd_data();
    chk("R7 ready clear", {7'd0, rx_ready}, 8'd0);

    // R3: 5-bit word, upper bits zero
    cfg_len = 2'd0;
    send(8'hF3, 1'b0, 1'b1);
    chk("R3 byte 5b", rx_byte, 8'h13);
    rd_data();
    cfg_len = 2'd3;

    // R2: short low pulse ignored
    rx_line = 1'b0; idle(16); rx_line = 1'b1; idle(4 * BIT_CLK);
    chk("R2 glitch ready", {7'd0, rx_ready}, 8'd0);
    chk("R2 glitch flags", flags(), 8'd0);
    send(8'h3C, 1'b0, 1'b1);
    chk("R2 after glitch", rx_byte, 8'h3C);
    rd_data();

    // R4: parity, R9 sticky and clear
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send(8'h5A, 1'b0, 1'b1);
    chk("R4 even good flags", flags(), 8'd0);
    rd_data();
    cfg_par_odd = 1'b1; cfg_len = 2'd2;
    send(8'h4B, 1'b1, 1'b1);
    chk("R4 odd bad flag", flags(), 8'h01);
    chk("R4 byte kept", rx_byte, 8'h4B);
    rd_data();
    send(8'h12, 1'b0, 1'b1);
    chk("R9 sticky", flags(), 8'h01);
    rd_data();
    rd_stat();
    chk("R9 cleared", flags(), 8'd0);
    cfg_par_en = 1'b0; cfg_len = 2'd3;

    // R5: frame error
    send(8'h55, 1'b0, 1'b0);
    chk("R5 frame flag", flags(), 8'h02);
    chk("R5 byte", rx_byte, 8'h55);
    rd_data(); rd_stat();

    // R6: break, no load, then recovery
    rx_line = 1'b0; idle(12 * BIT_CLK); rx_line = 1'b1; idle(2 * BIT_CLK);
    chk("R6 break flag", flags(), 8'h04);
    chk("R6 no load", {7'd0, rx_ready}, 8'd0);
    send(8'h81, 1'b0, 1'b1);
    chk("R6 recover", rx_byte, 8'h81);
    rd_data(); rd_stat();

    // R8: overrun keeps old byte
    send(8'h11, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b1);
    chk("R8 overrun flag", flags(), 8'h08);
    chk("R8 old byte kept", rx_byte, 8'h11);
    rd_data();
    chk("R8 ready clear", {7'd0, rx_ready}, 8'd0);
    rd_stat();

    // R10: back-to-back frames, read in between
    send(8'h6E, 1'b0, 1'b1);
    fork
      send(8'h9D, 1'b0, 1'b1);
      begin
        idle(8);
        chk("R10 first", rx_byte, 8'h6E);
        rd_data();
      end
    join
    chk("R10 second", rx_byte, 8'h9D);
    chk("R10 no overrun", flags(), 8'd0);
    rd_data();

    // random frames
    void'($urandom(32'h5EED));
    for (int n = 0; n < 40; n++) begin
      cfg_len = 2'($urandom % 4);
      cfg_par_en = 1'($urandom % 2);
      cfg_par_odd = 1'($urandom % 2);
      d = 8'($urandom);
      flip = cfg_par_en && ($urandom % 5 == 0);
      expb = d & len_mask(cfg_len);
      send(d, flip, 1'b1);
      chk("R3 rand byte", rx_byte, expb);
      chk("R4 rand flags", flags(), {7'd0, flip});
      rd_data(); rd_stat();
      chk("R7 rand clear", {7'd0, rx_ready}, 8'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule